// File: doc/BRIEF.md
# Run-Ahead Instruction Preserving Buffer

This block is a deep, strictly sequential FIFO that holds the stream of instructions retiring from the head of a reorder buffer while the core runs ahead of an outstanding long-latency miss. Each record keeps a completion flag, an operation class, a destination field and one shared value field. That value field carries the execution result for finished work, the effective address for a finished store (whose destination field then names the register that supplies the store data), or the raw instruction encoding when the instruction could not execute yet.

An instruction that is still waiting and whose outcome needs extra context takes a second, adjacent slot that holds that context. This applies to an unresolved branch (the companion slot holds its predicted target) and to an instruction that depends on the condition register (the companion slot holds the register's value). The write side places the whole record in one cycle. The replay side sees the record as one unit, with the companion value beside it, and removes it in one handshake. The write side owns any cycle in which it offers a record, so the two sides never move in the same cycle. A stall output tells the writer that the offered record does not fit. A one-cycle drained pulse marks the moment replay empties the buffer. A synchronous flush discards the contents.

Top module: `preserve_buf`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `deq_valid`=0, `drained`=0, and `enq_stall`=0 for any offered record.
- R2: A cycle with `flush`=1 empties the buffer at that clock edge: `empty`=1, `deq_valid`=0 and `drained`=0 afterwards. The next record written is the next one replayed.
- R3: Single-slot records are replayed in write order, with the completion flag, class, destination and value fields unchanged.
- R4: A record with completion flag 0 and class 3 (branch) or class 4 (condition-register dependent) occupies two slots. On replay, `deq_has_aux`=1 and `deq_aux` carries the companion value written with it, and one handshake consumes both slots.
- R5: Every other record occupies one slot and replays with `deq_has_aux`=0. This includes any record with completion flag 1, even one of class 3 or 4.
- R6: `enq_stall` is 1 when fewer free slots remain than the offered record needs. A record offered while stalled is not stored.
- R7: With exactly one free slot, a two-slot record is stalled while a single-slot record is accepted.
- R8: `full` is 1 exactly when every slot is occupied, and it returns to 0 after a replay handshake.
- R9: While `enq_valid`=1 the write side owns the cycle: `deq_valid`=0 and nothing is removed, even with `deq_ready`=1.
- R10: `drained` pulses high for one cycle, the cycle after the handshake that removes the last record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous discard of all contents |
| enq_valid | input | 1 | Write side offers a record |
| enq_done | input | 1 | Offered instruction has completed |
| enq_cls | input | 3 | Operation class (0 ALU, 1 load, 2 store, 3 branch, 4 condition-dependent) |
| enq_dst | input | DST_W | Destination field (store: data source register) |
| enq_val | input | VAL_W | Result, store address, or raw instruction encoding |
| enq_aux | input | VAL_W | Companion value for a two-slot record |
| enq_stall | output | 1 | Offered record does not fit |
| deq_ready | input | 1 | Replay side takes the head record |
| deq_valid | output | 1 | Head record is presented |
| deq_done | output | 1 | Head completion flag |
| deq_cls | output | 3 | Head operation class |
| deq_dst | output | DST_W | Head destination field |
| deq_val | output | VAL_W | Head value field |
| deq_aux | output | VAL_W | Companion value of the head record (0 if none) |
| deq_has_aux | output | 1 | Head record spans two slots |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slots occupied |
| drained | output | 1 | One-cycle pulse after replay empties the buffer |

## Verification
A write offer and a replay request can arrive in the same cycle, and the buffer must give that cycle to the writer alone. The bench provokes this by raising `enq_valid` and `deq_ready` together while records are already queued. It expects `deq_valid` to read low in that cycle. It then drains the buffer and expects the oldest record first, with the new record appended last, which shows that nothing was popped. The second collision, a two-slot record meeting a single free slot, is provoked by filling to one slot short of capacity and offering both record kinds in turn.

// File: rtl/pb_pkg.sv
// Shared definitions for the preserving buffer.
// Assumes class codes are fixed at 3 bits by the producing pipeline.
package pb_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_CCDEP  = 3'd4
    } pb_cls_e;

    // True when a record needs a companion slot: waiting branch or waiting condition user.
    function automatic logic needs_companion(input logic done, input logic [CLS_W-1:0] cls);
        return !done && (cls == CLS_BRANCH || cls == CLS_CCDEP);
    endfunction

endpackage

// File: rtl/pb_rec_pack.sv
// Builds the one or two storage words of a record from the write-side fields.
// Assumes the companion word carries its value in the low VAL_W bits.
module pb_rec_pack #(
    parameter int DST_W = 6,
    parameter int VAL_W = 32,
    localparam int ENT_W = 1 + pb_pkg::CLS_W + DST_W + VAL_W
) (
    input  logic                     done,
    input  logic [pb_pkg::CLS_W-1:0] cls,
    input  logic [DST_W-1:0]         dst,
    input  logic [VAL_W-1:0]         val,
    input  logic [VAL_W-1:0]         aux,
    output logic                     two_slot,
    output logic [ENT_W-1:0]         word0,
    output logic [ENT_W-1:0]         word1
);
    // Record packing and length decision.
    always_comb begin
        two_slot = pb_pkg::needs_companion(done, cls);
        word0    = {done, cls, dst, val};
        word1    = {{(ENT_W-VAL_W){1'b0}}, aux};
    end
endmodule

// File: rtl/pb_rec_unpack.sv
// Splits the head storage word into fields and attaches the companion value.
// Assumes the companion slot was written with the head word as one record.
module pb_rec_unpack #(
    parameter int DST_W = 6,
    parameter int VAL_W = 32,
    localparam int ENT_W = 1 + pb_pkg::CLS_W + DST_W + VAL_W
) (
    input  logic [ENT_W-1:0]         word0,
    input  logic [VAL_W-1:0]         next_val,
    output logic                     done,
    output logic [pb_pkg::CLS_W-1:0] cls,
    output logic [DST_W-1:0]         dst,
    output logic [VAL_W-1:0]         val,
    output logic                     has_aux,
    output logic [VAL_W-1:0]         aux
);
    // Field split and companion gating.
    always_comb begin
        {done, cls, dst, val} = word0;
        has_aux = pb_pkg::needs_companion(done, cls);
        aux     = has_aux ? next_val : '0;
    end
endmodule

// File: rtl/pb_store.sv
// Slot array: writes one or two consecutive slots, reads the head slot and the
// companion value of the slot after it. Pointers wrap because DEPTH is a power of two.
module pb_store #(
    parameter int DEPTH = 1024,
    parameter int W     = 42,
    parameter int AUX_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_two,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [W-1:0]     wr_word0,
    input  logic [W-1:0]     wr_word1,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [W-1:0]     rd_word0,
    output logic [AUX_W-1:0] rd_aux
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_next;
    logic [PTR_W-1:0] rd_next;

    assign wr_next = wr_ptr + PTR_W'(1);
    assign rd_next = rd_ptr + PTR_W'(1);

    // Slot writes: first word at the tail, companion word right after it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_word0;
            if (wr_two) begin
                mem[wr_next] <= wr_word1;
            end
        end
    end

    // Head read and companion read.
    assign rd_word0 = mem[rd_ptr];
    assign rd_aux   = mem[rd_next][AUX_W-1:0];
endmodule

// File: rtl/pb_ptr_ctrl.sv
// Head, tail and occupancy control. Grants the cycle to the write side when it
// offers a record, admits a record only if all its slots fit, and pops whole records.
// Assumes DEPTH is a power of two and at least 2.
module pb_ptr_ctrl #(
    parameter int DEPTH = 1024,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enq_valid,
    input  logic             enq_two,
    input  logic             deq_ready,
    input  logic             head_two,
    output logic             wr_en,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] head,
    output logic             enq_stall,
    output logic             deq_valid,
    output logic             full,
    output logic             empty,
    output logic             drained
);
    logic [PTR_W-1:0] tail_q, head_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] free_w, need_w, pop_len;
    logic             push_go, pop_go, drained_q;

    // Room check and side arbitration.
    always_comb begin
        free_w    = CNT_W'(DEPTH) - count_q;
        need_w    = enq_two ? CNT_W'(2) : CNT_W'(1);
        pop_len   = head_two ? CNT_W'(2) : CNT_W'(1);
        empty     = (count_q == '0);
        full      = (count_q == CNT_W'(DEPTH));
        enq_stall = (free_w < need_w);
        push_go   = enq_valid && !enq_stall && !flush;
        deq_valid = !empty && !enq_valid && !flush;
        pop_go    = deq_valid && deq_ready;
    end

    // Pointer, occupancy and drain-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tail_q    <= '0;
            head_q    <= '0;
            count_q   <= '0;
            drained_q <= 1'b0;
        end else begin
            drained_q <= pop_go && (count_q == pop_len);
            if (push_go) begin
                tail_q  <= tail_q + PTR_W'(need_w);
                count_q <= count_q + need_w;
            end else if (pop_go) begin
                head_q  <= head_q + PTR_W'(pop_len);
                count_q <= count_q - pop_len;
            end
        end
    end

    assign wr_en   = push_go;
    assign tail    = tail_q;
    assign head    = head_q;
    assign drained = drained_q;

    AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |=> count_q == $past(count_q) + $past(need_w)); // R3
    AST_HOLD_HEAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !flush) |=> head_q == $past(head_q)); // R9
    AST_STALL_KEEPS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_stall && !flush) |=> tail_q == $past(tail_q)); // R6
    AST_RECORD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0 && head_two) |-> count_q >= CNT_W'(2)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH)); // R8
    AST_DRAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        drained_q |=> !drained_q); // R10
endmodule

// File: rtl/preserve_buf.sv
// Preserving buffer top: in-order store of run-ahead retirement records with
// optional companion slot, replayed whole records at a time.
// Assumes the write and replay sides are driven by one mode controller; if both
// request in one cycle, the write side wins.
module preserve_buf #(
    parameter int DEPTH = 1024,
    parameter int DST_W = 6,
    parameter int VAL_W = 32,
    localparam int ENT_W = 1 + pb_pkg::CLS_W + DST_W + VAL_W,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enq_valid,
    input  logic             enq_done,
    input  logic [2:0]       enq_cls,
    input  logic [DST_W-1:0] enq_dst,
    input  logic [VAL_W-1:0] enq_val,
    input  logic [VAL_W-1:0] enq_aux,
    output logic             enq_stall,
    input  logic             deq_ready,
    output logic             deq_valid,
    output logic             deq_done,
    output logic [2:0]       deq_cls,
    output logic [DST_W-1:0] deq_dst,
    output logic [VAL_W-1:0] deq_val,
    output logic [VAL_W-1:0] deq_aux,
    output logic             deq_has_aux,
    output logic             full,
    output logic             empty,
    output logic             drained
);
    logic             enq_two;
    logic [ENT_W-1:0] wr_word0, wr_word1, rd_word0;
    logic [VAL_W-1:0] rd_aux;
    logic             wr_en;
    logic [PTR_W-1:0] tail, head;

    pb_rec_pack #(.DST_W(DST_W), .VAL_W(VAL_W)) u_pack (
        .done(enq_done), .cls(enq_cls), .dst(enq_dst), .val(enq_val), .aux(enq_aux),
        .two_slot(enq_two), .word0(wr_word0), .word1(wr_word1)
    );

    pb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enq_valid(enq_valid), .enq_two(enq_two),
        .deq_ready(deq_ready), .head_two(deq_has_aux),
        .wr_en(wr_en), .tail(tail), .head(head),
        .enq_stall(enq_stall), .deq_valid(deq_valid),
        .full(full), .empty(empty), .drained(drained)
    );

    pb_store #(.DEPTH(DEPTH), .W(ENT_W), .AUX_W(VAL_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_two(enq_two), .wr_ptr(tail),
        .wr_word0(wr_word0), .wr_word1(wr_word1),
        .rd_ptr(head), .rd_word0(rd_word0), .rd_aux(rd_aux)
    );

    pb_rec_unpack #(.DST_W(DST_W), .VAL_W(VAL_W)) u_unpack (
        .word0(rd_word0), .next_val(rd_aux),
        .done(deq_done), .cls(deq_cls), .dst(deq_dst), .val(deq_val),
        .has_aux(deq_has_aux), .aux(deq_aux)
    );

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> enq_stall); // R8
    AST_ONE_SIDE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |-> !deq_valid); // R9
endmodule

// File: tb/preserve_buf_bench.sv
`timescale 1ns/1ps
module preserve_buf_bench;
    localparam int DEPTH = 16;
    localparam int DST_W = 6;
    localparam int VAL_W = 32;
    localparam int REC_W = 1 + 3 + DST_W + VAL_W + VAL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             enq_valid = 1'b0, enq_done = 1'b0;
    logic [2:0]       enq_cls = '0;
    logic [DST_W-1:0] enq_dst = '0;
    logic [VAL_W-1:0] enq_val = '0, enq_aux = '0;
    logic             enq_stall;
    logic             deq_ready = 1'b0;
    logic             deq_valid, deq_done, deq_has_aux;
    logic [2:0]       deq_cls;
    logic [DST_W-1:0] deq_dst;
    logic [VAL_W-1:0] deq_val, deq_aux;
    logic             full, empty, drained;

    int n_chk = 0;
    int n_bad = 0;
    logic [REC_W-1:0] mq[$];

    always #5 clk = ~clk;

    preserve_buf #(.DEPTH(DEPTH), .DST_W(DST_W), .VAL_W(VAL_W)) u_preserve_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enq_valid(enq_valid), .enq_done(enq_done), .enq_cls(enq_cls),
        .enq_dst(enq_dst), .enq_val(enq_val), .enq_aux(enq_aux), .enq_stall(enq_stall),
        .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_done(deq_done),
        .deq_cls(deq_cls), .deq_dst(deq_dst), .deq_val(deq_val), .deq_aux(deq_aux),
        .deq_has_aux(deq_has_aux), .full(full), .empty(empty), .drained(drained)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic two_of(input logic d, input logic [2:0] c);
        return !d && (c == 3'd3 || c == 3'd4);
    endfunction

    // Offer one record for one cycle; the model keeps it only when not stalled.
    task automatic push(input logic d, input logic [2:0] c, input logic [DST_W-1:0] ds,
                        input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] a);
        @(negedge clk);
        enq_valid = 1'b1; enq_done = d; enq_cls = c; enq_dst = ds; enq_val = v; enq_aux = a;
        #1;
        if (!enq_stall) mq.push_back({d, c, ds, v, two_of(d, c) ? a : '0});
        @(posedge clk); #1;
        enq_valid = 1'b0;
    endtask

    // Take the head record and compare it with the model.
    task automatic pop_chk(input string req);
        logic [REC_W-1:0] e;
        e = mq[0];
        @(negedge clk);
        deq_ready = 1'b1;
        #1;
        chk({req, " valid"}, 64'(deq_valid), 64'd1);
        chk({req, " done"},  64'(deq_done), 64'(e[REC_W-1]));
        chk({req, " cls"},   64'(deq_cls), 64'(e[REC_W-2 -: 3]));
        chk({req, " dst"},   64'(deq_dst), 64'(e[2*VAL_W +: DST_W]));
        chk({req, " val"},   64'(deq_val), 64'(e[VAL_W +: VAL_W]));
        chk({req, " aux"},   64'(deq_aux), 64'(e[0 +: VAL_W]));
        chk({req, " has_aux"}, 64'(deq_has_aux), 64'(two_of(e[REC_W-1], e[REC_W-2 -: 3])));
        @(posedge clk); #1;
        deq_ready = 1'b0;
        void'(mq.pop_front());
    endtask

    task automatic drain_all(input string req);
        while (mq.size() > 0) pop_chk(req);
        chk("R10 drained pulse", 64'(drained), 64'd1);
        chk("R10 empty after drain", 64'(empty), 64'd1);
        @(posedge clk); #1;
        chk("R10 drained one cycle", 64'(drained), 64'd0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 empty", 64'(empty), 64'd1);
        chk("R1 full", 64'(full), 64'd0);
        chk("R1 deq_valid", 64'(deq_valid), 64'd0);
        chk("R1 drained", 64'(drained), 64'd0);
        chk("R1 stall", 64'(enq_stall), 64'd0);
    endtask

    task automatic t_order();
        push(1'b1, 3'd0, 6'd5,  32'h1111_0001, 32'hdead);
        push(1'b1, 3'd1, 6'd9,  32'h2222_0002, 32'h0);
        push(1'b1, 3'd2, 6'd17, 32'h8000_1000, 32'h0);
        push(1'b0, 3'd0, 6'd33, 32'hfeed_0004, 32'h0);
        push(1'b0, 3'd1, 6'd63, 32'hc0de_0005, 32'h0);
        drain_all("R3 order");
    endtask

    task automatic t_two_slot();
        push(1'b0, 3'd3, 6'd1, 32'hb000_0001, 32'h0040_1000);
        push(1'b1, 3'd0, 6'd2, 32'h0000_00aa, 32'h0);
        push(1'b0, 3'd4, 6'd3, 32'hcc00_0003, 32'h0000_000f);
        push(1'b1, 3'd3, 6'd4, 32'h0040_2000, 32'h1234);
        push(1'b1, 3'd4, 6'd5, 32'h0000_0055, 32'h5678);
        pop_chk("R4 branch");
        pop_chk("R5 alu");
        pop_chk("R4 ccdep");
        pop_chk("R5 done branch");
        pop_chk("R5 done ccdep");
        @(posedge clk); #1;
        chk("R4 empty after records", 64'(empty), 64'd1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH - 1; i++) push(1'b1, 3'd0, 6'(i), 32'(i * 3 + 7), 32'h0);
        chk("R8 not full", 64'(full), 64'd0);
        @(negedge clk);
        enq_valid = 1'b1; enq_done = 1'b0; enq_cls = 3'd3; enq_val = 32'hbad0; enq_aux = 32'hbad1;
        #1;
        chk("R7 two-slot stalls", 64'(enq_stall), 64'd1);
        enq_done = 1'b1; enq_cls = 3'd0; enq_dst = 6'd50; enq_val = 32'h5a5a;
        #1;
        chk("R7 single fits", 64'(enq_stall), 64'd0);
        mq.push_back({1'b1, 3'd0, 6'd50, 32'h5a5a, 32'h0});
        @(posedge clk); #1;
        enq_valid = 1'b0;
        chk("R8 full", 64'(full), 64'd1);
        @(negedge clk);
        enq_valid = 1'b1; enq_val = 32'hbad2;
        #1;
        chk("R6 stall when full", 64'(enq_stall), 64'd1);
        @(posedge clk); #1;
        enq_valid = 1'b0;
        chk("R6 still full", 64'(full), 64'd1);
        pop_chk("R8 first pop");
        chk("R8 full clears", 64'(full), 64'd0);
        drain_all("R6 no stray record");
    endtask

    task automatic t_priority();
        push(1'b1, 3'd0, 6'd7, 32'h0a0a_0001, 32'h0);
        push(1'b1, 3'd1, 6'd8, 32'h0a0a_0002, 32'h0);
        @(negedge clk);
        enq_valid = 1'b1; enq_done = 1'b1; enq_cls = 3'd2; enq_dst = 6'd9; enq_val = 32'h0a0a_0003;
        deq_ready = 1'b1;
        #1;
        chk("R9 deq blocked", 64'(deq_valid), 64'd0);
        mq.push_back({1'b1, 3'd2, 6'd9, 32'h0a0a_0003, 32'h0});
        @(posedge clk); #1;
        enq_valid = 1'b0; deq_ready = 1'b0;
        chk("R9 nothing removed", 64'(mq.size()), 64'd3);
        drain_all("R9 order kept");
    endtask

    task automatic t_flush();
        push(1'b1, 3'd0, 6'd1, 32'h1, 32'h0);
        push(1'b0, 3'd3, 6'd2, 32'h2, 32'h3);
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        mq.delete();
        chk("R2 empty", 64'(empty), 64'd1);
        chk("R2 no deq", 64'(deq_valid), 64'd0);
        chk("R2 no drain pulse", 64'(drained), 64'd0);
        push(1'b1, 3'd1, 6'd44, 32'h7777_0000, 32'h0);
        drain_all("R2 after flush");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_two_slot();
        t_fill();
        t_priority();
        t_flush();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule